// File: doc/BRIEF.md
# Strobe-Written Double-Rate Read Capture Queue

This block sits at the receive edge of a flash or card interface. It takes a double-data-rate data bus that is launched against a gated source strobe, and returns each strobe cycle to the local `clk_phy` domain as two words: the word captured on the strobe's rising edge and the word captured on its falling edge. Eight entries form a small ring. The strobe side fills them in order, and the write pointer wraps after the eighth strobe cycle.

No consumer asks for data. The read pointer moves under an internal enable, and a mode bit chooses where that enable comes from. In the first mode it is the read-enable pulse of the DFI interface, delayed by a programmable number of `clk_phy` cycles to cover flight time and device access time. In the second mode it comes from the queue's own not-empty status. Reading starts once the queue has been seen as non-empty for a programmed number of cycles, and then continues one entry per cycle. Each entry that is read appears on the two data outputs together with a one-cycle valid pulse.

Top module: `ddr_rd_capture_fifo`

## Requirements
- R1: An active-low reset (asynchronous) clears the write pointer, the read pointer and the pointer synchronizer. It also drives `rd_valid`, `datain_h` and `datain_l` to zero. Data written before a reset is never read out after it.
- R2: Each strobe cycle fills one entry: the `dq` value on the strobe's rising edge and the `dq` value on its falling edge. The write pointer advances on the falling edge, after both halves are stored. Entries are read in write order across the wrap of the 8-entry ring.
- R3: Each read places the rising-edge word on `datain_h` and the falling-edge word of the same entry on `datain_l`. `rd_valid` is high for exactly one `clk_phy` cycle per entry read, and both data outputs hold their value between reads.
- R4: With `cfg_sync_empty` = 0, suppose `rddata_en` is sampled high at `clk_phy` edge k. One entry is then read at edge k + `cfg_en_dly`, so `rd_valid` is high in the cycle that follows that edge. This applies to every sampled-high cycle of `rddata_en`, and `cfg_en_dly` may be 0 to 7.
- R5: With `cfg_sync_empty` = 1, reading starts once the queue has been non-empty for `cfg_empty_dly` consecutive cycles. It then proceeds one entry per cycle while the queue stays non-empty. Raising `cfg_empty_dly` by d delays the first `rd_valid` by exactly d cycles.
- R6: No entry is read while the queue is empty. If `rddata_en` is high while the queue is empty, it produces no `rd_valid` and does not move the read pointer.
- R7: In the not-empty mode with `cfg_empty_dly` = 0, the first `rd_valid` comes no more than 8 `clk_phy` cycles after the strobe cycle that wrote the entry.
- R8: The write pointer is Gray-coded and crosses into `clk_phy` through two flops. The synchronized value changes by at most one bit per cycle.
- R9: The synchronized occupancy never exceeds 8 entries, and the read pointer moves by at most one entry per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_phy | input | 1 | Local clock of the read side |
| rst_n | input | 1 | Active-low reset, asynchronous, for both sides |
| strobe | input | 1 | Gated read strobe; both edges capture data |
| dq | input | DW (8) | Double-rate read data bus |
| rddata_en | input | 1 | DFI read-enable pulse, in the `clk_phy` domain |
| cfg_sync_empty | input | 1 | Read-advance source: 0 = delayed read-enable, 1 = delayed not-empty |
| cfg_en_dly | input | DLYW (3) | Delay in cycles applied to `rddata_en` |
| cfg_empty_dly | input | DLYW (3) | Cycles of not-empty required before reading starts |
| datain_h | output | DW (8) | Rising-edge word of the entry just read |
| datain_l | output | DW (8) | Falling-edge word of the entry just read |
| rd_valid | output | 1 | High for one cycle per entry read |

## Verification
The bench measures the exact cycle of the first `rd_valid` against the cycle in which `rddata_en` was driven, for several delays. A tap that is off by one moves that cycle and is reported. In the not-empty mode it compares the first-read cycle at zero delay with the first-read cycle at larger delays. A counter that starts late, or that never clears while the queue is empty, gives a wrong difference. The runs together pass the write pointer over its wrap, so a ring that overwrote or reordered entries, or swapped the two halves, would return the wrong words. Two directed cases complete the set. One pulses the read enable against an empty queue, where a design without the empty guard would emit data that was never written. The other resets the block with entries pending, where a design that left a pointer uncleared would deliver old data.

// File: rtl/ddr_rd_capture_fifo.sv
module ddr_rd_capture_fifo #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int DLYW  = 3
) (
  input  logic            clk_phy,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [DW-1:0]   dq,
  input  logic            rddata_en,
  input  logic            cfg_sync_empty,
  input  logic [DLYW-1:0] cfg_en_dly,
  input  logic [DLYW-1:0] cfg_empty_dly,
  output logic [DW-1:0]   datain_h,
  output logic [DW-1:0]   datain_l,
  output logic            rd_valid
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int MAXD  = (1 << DLYW) - 1;

  logic [DW-1:0]   rise_mem [DEPTH];
  logic [DW-1:0]   fall_mem [DEPTH];
  logic [PW-1:0]   wptr, wgray, wptr_nxt;
  logic [PW-1:0]   wg_s1, wg_s2, wbin_s, rptr;
  logic [MAXD-1:0] en_sr;
  logic [MAXD:0]   en_tap;
  logic [DLYW-1:0] ne_cnt;
  logic            empty, en_dly, adv;

  // strobe side: rising half, then falling half, then pointer moves
  always_ff @(posedge strobe)
    rise_mem[wptr[AW-1:0]] <= dq;

  always_ff @(negedge strobe)
    fall_mem[wptr[AW-1:0]] <= dq;

  assign wptr_nxt = wptr + 1'b1;

  always_ff @(negedge strobe or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= wptr_nxt ^ (wptr_nxt >> 1);
    end

  // clk_phy side
  always_ff @(posedge clk_phy or negedge rst_n)
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end

  always_comb begin
    wbin_s[PW-1] = wg_s2[PW-1];
    for (int i = PW - 2; i >= 0; i--)
      wbin_s[i] = wbin_s[i+1] ^ wg_s2[i];
  end

  assign empty  = (wbin_s == rptr);
  assign en_tap = {en_sr, rddata_en};
  assign en_dly = en_tap[cfg_en_dly];
  assign adv    = !empty && (cfg_sync_empty ? (ne_cnt >= cfg_empty_dly) : en_dly);

  always_ff @(posedge clk_phy or negedge rst_n)
    if (!rst_n) begin
      en_sr  <= '0;
      ne_cnt <= '0;
    end else begin
      en_sr <= en_tap[MAXD-1:0];
      if (empty)
        ne_cnt <= '0;
      else if (ne_cnt != DLYW'(MAXD))
        ne_cnt <= ne_cnt + 1'b1;
    end

  always_ff @(posedge clk_phy or negedge rst_n)
    if (!rst_n) begin
      rptr     <= '0;
      rd_valid <= 1'b0;
      datain_h <= '0;
      datain_l <= '0;
    end else begin
      rd_valid <= adv;
      if (adv) begin
        rptr     <= rptr + 1'b1;
        datain_h <= rise_mem[rptr[AW-1:0]];
        datain_l <= fall_mem[rptr[AW-1:0]];
      end
    end

  assert_gray_one_bit_R8: assert property (@(posedge clk_phy) disable iff (!rst_n)
    $countones(wg_s2 ^ $past(wg_s2)) <= 1);

  assert_no_overflow_R9: assert property (@(posedge clk_phy) disable iff (!rst_n)
    (wbin_s - rptr) <= PW'(DEPTH));

  assert_rptr_step_R9: assert property (@(posedge clk_phy) disable iff (!rst_n)
    (rptr != $past(rptr)) |-> (rptr == $past(rptr) + 1'b1));

  assert_valid_moves_rptr_R3: assert property (@(posedge clk_phy) disable iff (!rst_n)
    rd_valid |-> (rptr != $past(rptr)));

  assert_no_read_when_empty_R6: assert property (@(posedge clk_phy) disable iff (!rst_n)
    rd_valid |-> ($past(wbin_s) != $past(rptr)));

  assert_en_zero_delay_R4: assert property (@(posedge clk_phy) disable iff (!rst_n)
    (!$past(cfg_sync_empty) && $past(cfg_en_dly) == '0 && !$past(rddata_en)) |-> !rd_valid);

  assert_empty_hold_R5: assert property (@(posedge clk_phy) disable iff (!rst_n)
    (rd_valid && $past(cfg_sync_empty)) |-> ($past(ne_cnt) >= $past(cfg_empty_dly)));
endmodule

// File: tb/tb_ddr_rd_capture_fifo.sv
`timescale 1ns/1ps
module tb_ddr_rd_capture_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {mode[15], dly[14:12], n[11:8], base[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 3'd0, 4'd4, 8'h10},
    {1'b0, 3'd3, 4'd8, 8'h20},
    {1'b0, 3'd7, 4'd2, 8'h40},
    {1'b1, 3'd0, 4'd5, 8'h50},
    {1'b1, 3'd3, 4'd8, 8'h60},
    {1'b1, 3'd6, 4'd3, 8'h80}
  };

  logic       clk_phy = 0, rst_n = 0, strobe = 0, rddata_en = 0, cfg_sync_empty = 0;
  logic [7:0] dq = 0;
  logic [2:0] cfg_en_dly = 0, cfg_empty_dly = 0;
  logic [7:0] datain_h, datain_l;
  logic       rd_valid;

  int cyc = 0, errors = 0, checks = 0, got_n = 0, lat0 = 0;
  logic [7:0] got_h [64];
  logic [7:0] got_l [64];
  int         got_c [64];

  ddr_rd_capture_fifo dut (
    .clk_phy(clk_phy), .rst_n(rst_n), .strobe(strobe), .dq(dq),
    .rddata_en(rddata_en), .cfg_sync_empty(cfg_sync_empty),
    .cfg_en_dly(cfg_en_dly), .cfg_empty_dly(cfg_empty_dly),
    .datain_h(datain_h), .datain_l(datain_l), .rd_valid(rd_valid));

  always #(CLK_PERIOD/2) clk_phy = ~clk_phy;
  always @(posedge clk_phy) cyc <= cyc + 1;
  always @(negedge clk_phy)
    if (rst_n && rd_valid && got_n < 64) begin
      got_h[got_n] = datain_h;
      got_l[got_n] = datain_l;
      got_c[got_n] = cyc;
      got_n = got_n + 1;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_phy);
      dq = base + 8'(2*i);
      #2 strobe = 1;
      #3 dq = base + 8'(2*i + 1);
      #2 strobe = 0;
    end
  endtask

  task automatic pulse_en(input int n);
    @(negedge clk_phy);
    rddata_en = 1;
    repeat (n) @(negedge clk_phy);
    rddata_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_phy);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int start, m, d, n;
    logic [7:0] base;
    idle(3);
    // R1: reset state
    check(rd_valid == 0 && datain_h == 0 && datain_l == 0, "R1 reset outputs",
          {datain_h, datain_l, 7'd0, rd_valid}, 0);
    rst_n = 1;
    idle(3);

    // R2 R3 R4 R5 R7 R8 R9: table walk, pointer wraps across rows
    foreach (VEC[v]) begin
      m = VEC[v][15]; d = VEC[v][14:12]; n = VEC[v][11:8]; base = VEC[v][7:0];
      cfg_sync_empty = m[0];
      cfg_en_dly = 3'(d);
      cfg_empty_dly = 3'(d);
      idle(1);
      got_n = 0;
      if (m == 0) begin
        burst(n, base);
        idle(6);
        @(negedge clk_phy);
        start = cyc;
        rddata_en = 1;
        repeat (n) @(negedge clk_phy);
        rddata_en = 0;
        idle(20);
        check(got_n > 0 && got_c[0] == start + 1 + d, "R4 first valid cycle",
              got_n > 0 ? got_c[0] - start : -1, 1 + d);
      end else begin
        @(negedge clk_phy);
        start = cyc;
        burst(n, base);
        idle(25);
        if (d == 0) begin
          lat0 = got_n > 0 ? got_c[0] - start : -1;
          check(lat0 >= 2 && lat0 <= 8, "R7 latency bound", lat0, 8);
        end else
          check(got_n > 0 && got_c[0] - start == lat0 + d, "R5 empty delay shift",
                got_n > 0 ? got_c[0] - start : -1, lat0 + d);
      end
      check(got_n == n, "R3 one valid per entry", got_n, n);
      for (int i = 0; i < got_n && i < n; i++) begin
        check(got_h[i] == base + 8'(2*i), "R2 R3 high word order", got_h[i], base + 2*i);
        check(got_l[i] == base + 8'(2*i+1), "R3 low word", got_l[i], base + 2*i + 1);
      end
      if (m == 1 && got_n == n)
        check(got_c[n-1] - got_c[0] == n - 1, "R5 one read per cycle",
              got_c[n-1] - got_c[0], n - 1);
    end

    // R3: outputs hold between reads
    check(datain_h == 8'h84 && datain_l == 8'h85, "R3 hold after last read",
          {datain_h, datain_l}, 16'h8485);

    // R6: read enable against empty queue is ignored
    cfg_sync_empty = 0; cfg_en_dly = 3'd2;
    idle(2);
    got_n = 0;
    pulse_en(4);
    idle(10);
    check(got_n == 0, "R6 no read when empty", got_n, 0);
    burst(2, 8'hC0);
    idle(6);
    pulse_en(2);
    idle(10);
    check(got_n == 2 && got_h[0] == 8'hC0, "R6 read pointer unmoved",
          got_n > 0 ? got_h[0] : -1, 8'hC0);

    // R1: reset with pending entries discards them
    burst(3, 8'hE0);
    idle(2);
    @(negedge clk_phy); rst_n = 0;
    idle(1);
    check(rd_valid == 0 && datain_h == 0, "R1 mid-run reset outputs", datain_h, 0);
    rst_n = 1;
    idle(6);
    got_n = 0;
    pulse_en(3);
    idle(10);
    check(got_n == 0, "R1 pending data dropped", got_n, 0);
    burst(2, 8'hA0);
    idle(6);
    pulse_en(2);
    idle(10);
    check(got_n == 2 && got_h[0] == 8'hA0 && got_l[1] == 8'hA3, "R1 pointers restart at zero",
          got_n > 0 ? got_h[0] : -1, 8'hA0);

    finish_run();
  end
endmodule